// File: doc/BRIEF.md
# Modem Handshake Status Register

This block is the modem-status slice of a 16550-compatible serial port. It watches three active-low handshake pins from the modem (clear to send, data set ready, carrier detect). Each pin crosses into the core clock through a synchroniser. The block shows the inverted pin levels in an 8-bit status byte and keeps a sticky delta flag for each pin. A delta flag is set when its pin returns from low to high.

A host reads the byte by asserting a one-cycle read strobe. The byte is always visible on the read data bus. The clock edge that ends the strobe clears the delta flags. A separate interrupt tracker remembers any change of level on any of the three pins since the last read, in either direction. It drives a level interrupt request while the modem-status enable bit from the interrupt enable register is 1.

Top module: `modem_stat_unit`

## Requirements
- R1: Status bit 4 equals the inverse of the clear-to-send pin, bit 5 the inverse of the data-set-ready pin, and bit 7 the inverse of the carrier-detect pin. Each follows its pin two clock edges after the pin is sampled.
- R2: Status bit 0 becomes 1 one clock after the synchronised clear-to-send pin goes from 0 to 1. It then stays 1 until a read clears it.
- R3: Status bit 1 behaves as in R2 for the data-set-ready pin.
- R4: Status bit 3 behaves as in R2 for the carrier-detect pin.
- R5: A pin going from 1 to 0 sets no delta flag.
- R6: The byte read while the strobe is high holds the flags as they stood before the read. The clock edge that ends the strobe clears bits 0, 1 and 3.
- R7: If a rising pin transition is detected in the same clock as a clearing read, that pin's delta flag is 1 after the read.
- R8: Status bits 2 and 6 always read 0.
- R9: The interrupt request is 1 when the enable input is 1 and any of the three synchronised pins has changed level, in either direction, since the last read. It is visible in the same cycle as the delta flags.
- R10: With the enable input at 0 the request is 0. A pending change is kept, and the request reappears once the enable returns to 1.
- R11: A read with no change detected in the same clock drops the request on the next cycle.
- R12: After reset, with the pins held high, the status byte is 0x00 and the request is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cts_n_pin | input | 1 | Clear-to-send pin, active low, asynchronous |
| dsr_n_pin | input | 1 | Data-set-ready pin, active low, asynchronous |
| dcd_n_pin | input | 1 | Carrier-detect pin, active low, asynchronous |
| ier_msi_en | input | 1 | Modem-status interrupt enable from the interrupt enable register |
| rd_stb | input | 1 | One-cycle strobe that reads and clears the status byte |
| rd_data | output | 8 | Status byte |
| msi_irq | output | 1 | Level modem-status interrupt request |

## Verification
A detected rising pin transition and a clearing read can land on the same clock edge. The delta flag must then survive the read (R7), and the interrupt must stay pending. The bench provokes this directly by raising clear to send and asserting the strobe in exactly the second cycle after synchronisation. Random pin toggling with frequent reads also produces many more such coincidences on all three pins. Every cycle is judged against a bench-side model that applies set-over-clear priority to both the flags and the pending interrupt.

// File: rtl/msr_pkg.sv
package msr_pkg;

    // Line index inside the handshake vector
    localparam int LINE_CTS   = 0;
    localparam int LINE_DSR   = 1;
    localparam int LINE_DCD   = 2;
    localparam int NUM_LINES  = 3;

    // Status byte layout (decoded by host software, so fixed)
    localparam int BIT_D_CTS  = 0;
    localparam int BIT_D_DSR  = 1;
    localparam int BIT_RSV_LO = 2;
    localparam int BIT_D_DCD  = 3;
    localparam int BIT_L_CTS  = 4;
    localparam int BIT_L_DSR  = 5;
    localparam int BIT_RSV_HI = 6;
    localparam int BIT_L_DCD  = 7;

    // Interrupt tracker states
    typedef enum logic {
        IRQ_QUIET   = 1'b0,
        IRQ_PENDING = 1'b1
    } irq_state_t;

endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int WIDTH     = 3,
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= {WIDTH{RESET_VAL}};
                else        stage_q[s] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= {WIDTH{RESET_VAL}};
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/msr_edge.sv
module msr_edge #(
    parameter int WIDTH     = 3,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] change
);

    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= {WIDTH{RESET_VAL}};
        else        prev_q <= level;
    end

    always_comb begin
        rise   = level & ~prev_q;
        change = level ^ prev_q;
    end

endmodule

// File: rtl/msr_delta.sv
module msr_delta #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rise,
    input  logic             clr,
    output logic [WIDTH-1:0] flags
);

    logic [WIDTH-1:0] flags_q;
    logic [WIDTH-1:0] flags_d;

    // set has priority over the clearing read
    always_comb begin
        flags_d = (flags_q & {WIDTH{~clr}}) | rise;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags = flags_q;

endmodule

// File: rtl/msr_irq_fsm.sv
module msr_irq_fsm
    import msr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic any_change,
    input  logic clr,
    input  logic enable,
    output logic irq
);

    irq_state_t state_q;
    irq_state_t state_d;

    // next-state: EV_CHANGE moves to pending, EV_ACK (read, no new change) back to quiet
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_QUIET: begin
                if (any_change) state_d = IRQ_PENDING;
            end
            IRQ_PENDING: begin
                if (clr && !any_change) state_d = IRQ_QUIET;
            end
            default: state_d = IRQ_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        irq = 1'b0;
        unique case (state_q)
            IRQ_QUIET:   irq = 1'b0;
            IRQ_PENDING: irq = enable;
            default:     irq = 1'b0;
        endcase
    end

endmodule

// File: rtl/modem_stat_unit.sv
module modem_stat_unit
    import msr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cts_n_pin,
    input  logic       dsr_n_pin,
    input  logic       dcd_n_pin,
    input  logic       ier_msi_en,
    input  logic       rd_stb,
    output logic [7:0] rd_data,
    output logic       msi_irq
);

    logic [NUM_LINES-1:0] pins_raw;
    logic [NUM_LINES-1:0] pins_sync;
    logic [NUM_LINES-1:0] edge_rise;
    logic [NUM_LINES-1:0] edge_chg;
    logic [NUM_LINES-1:0] delta_q;

    always_comb begin
        pins_raw           = '0;
        pins_raw[LINE_CTS] = cts_n_pin;
        pins_raw[LINE_DSR] = dsr_n_pin;
        pins_raw[LINE_DCD] = dcd_n_pin;
    end

    msr_sync #(
        .WIDTH    (NUM_LINES),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL(1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pins_raw),
        .sync_out(pins_sync)
    );

    msr_edge #(
        .WIDTH    (NUM_LINES),
        .RESET_VAL(1'b1)
    ) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (pins_sync),
        .rise  (edge_rise),
        .change(edge_chg)
    );

    msr_delta #(
        .WIDTH(NUM_LINES)
    ) u_delta (
        .clk  (clk),
        .rst_n(rst_n),
        .rise (edge_rise),
        .clr  (rd_stb),
        .flags(delta_q)
    );

    msr_irq_fsm u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_change(|edge_chg),
        .clr       (rd_stb),
        .enable    (ier_msi_en),
        .irq       (msi_irq)
    );

    always_comb begin
        rd_data             = '0;
        rd_data[BIT_D_CTS]  = delta_q[LINE_CTS];
        rd_data[BIT_D_DSR]  = delta_q[LINE_DSR];
        rd_data[BIT_RSV_LO] = 1'b0;
        rd_data[BIT_D_DCD]  = delta_q[LINE_DCD];
        rd_data[BIT_L_CTS]  = ~pins_sync[LINE_CTS];
        rd_data[BIT_L_DSR]  = ~pins_sync[LINE_DSR];
        rd_data[BIT_RSV_HI] = 1'b0;
        rd_data[BIT_L_DCD]  = ~pins_sync[LINE_DCD];
    end

endmodule

// File: rtl/msr_checker.sv
module msr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cts_n_pin,
    input logic       dsr_n_pin,
    input logic       dcd_n_pin,
    input logic       ier_msi_en,
    input logic       rd_stb,
    input logic [7:0] rd_data,
    input logic       msi_irq,
    input logic [2:0] rise,
    input logic [2:0] chg
);

    logic [1:0] age_q;
    logic [2:0] dl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             age_q <= 2'd0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    assign dl = {rd_data[3], rd_data[1], rd_data[0]};

    assert_level_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (rd_data[4] == !$past(cts_n_pin, 2)
                          && rd_data[5] == !$past(dsr_n_pin, 2)
                          && rd_data[7] == !$past(dcd_n_pin, 2)));

    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb) |=> ((dl & $past(dl)) == $past(dl)));

    assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((dl & $past(rise)) == $past(rise)));

    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> (dl == $past(rise)));

    assert_rsv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[2] == 1'b0) && (rd_data[6] == 1'b0));

    assert_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|chg) |=> (msi_irq || !ier_msi_en));

    assert_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        msi_irq |-> ier_msi_en);

    assert_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !(|chg)) |=> !msi_irq);

endmodule

bind modem_stat_unit msr_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cts_n_pin (cts_n_pin),
    .dsr_n_pin (dsr_n_pin),
    .dcd_n_pin (dcd_n_pin),
    .ier_msi_en(ier_msi_en),
    .rd_stb    (rd_stb),
    .rd_data   (rd_data),
    .msi_irq   (msi_irq),
    .rise      (edge_rise),
    .chg       (edge_chg)
);

// File: tb/sim_modem_stat_unit.sv
`timescale 1ns/1ps
module sim_modem_stat_unit;

    localparam int WD_CYCLES = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cts_n_pin = 1'b1;
    logic       dsr_n_pin = 1'b1;
    logic       dcd_n_pin = 1'b1;
    logic       ier_msi_en = 1'b1;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       msi_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    modem_stat_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .cts_n_pin (cts_n_pin),
        .dsr_n_pin (dsr_n_pin),
        .dcd_n_pin (dcd_n_pin),
        .ier_msi_en(ier_msi_en),
        .rd_stb    (rd_stb),
        .rd_data   (rd_data),
        .msi_irq   (msi_irq)
    );

    // Bench model, index 0 cts, 1 dsr, 2 dcd
    logic [2:0] m_s1, m_s2, m_prev, m_flag;
    logic       m_pend;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 3'b111; m_s2 <= 3'b111; m_prev <= 3'b111;
            m_flag <= 3'b000; m_pend <= 1'b0;
        end else begin
            m_s1   <= {dcd_n_pin, dsr_n_pin, cts_n_pin};
            m_s2   <= m_s1;
            m_prev <= m_s2;
            m_flag <= (rd_stb ? 3'b000 : m_flag) | (m_s2 & ~m_prev);
            m_pend <= (rd_stb ? 1'b0 : m_pend) | (|(m_s2 ^ m_prev));
        end
    end

    function automatic logic [7:0] exp_byte();
        return {~m_s2[2], 1'b0, ~m_s2[1], ~m_s2[0], m_flag[2], 1'b0, m_flag[1], m_flag[0]};
    endfunction

    function automatic logic exp_irq();
        return ier_msi_en & m_pend;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [7:0] e;
        e = exp_byte();
        check("R1 level bits", {5'd0, rd_data[7], rd_data[5], rd_data[4]}, {5'd0, e[7], e[5], e[4]});
        check("R2 cts delta", {7'd0, rd_data[0]}, {7'd0, e[0]});
        check("R3 dsr delta", {7'd0, rd_data[1]}, {7'd0, e[1]});
        check("R4 dcd delta", {7'd0, rd_data[3]}, {7'd0, e[3]});
        check("R8 reserved bits", {6'd0, rd_data[6], rd_data[2]}, 8'd0);
        check("R9 irq", {7'd0, msi_irq}, {7'd0, exp_irq()});
    endtask

    // called at a negative edge: drive, advance one clock, compare
    task automatic step(input logic [2:0] pins, input logic rd, input logic en);
        cts_n_pin  = pins[0];
        dsr_n_pin  = pins[1];
        dcd_n_pin  = pins[2];
        rd_stb     = rd;
        ier_msi_en = en;
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic hold(input logic [2:0] pins, input logic en, input int n);
        for (int i = 0; i < n; i++) step(pins, 1'b0, en);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        logic [2:0] pins;
        logic       en;
        void'($urandom(32'h1234_5EED));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check("R12 reset byte", rd_data, 8'h00);
        check("R12 reset irq", {7'd0, msi_irq}, 8'h00);
        hold(3'b111, 1'b1, 3);

        // cts falls: level set, no delta, irq from change
        hold(3'b110, 1'b1, 4);
        check("R1 cts level", {7'd0, rd_data[4]}, 8'h01);
        check("R5 falling no delta", {5'd0, rd_data[3], rd_data[1], rd_data[0]}, 8'h00);
        check("R9 irq on fall", {7'd0, msi_irq}, 8'h01);
        step(3'b110, 1'b1, 1'b1);
        check("R11 irq dropped by read", {7'd0, msi_irq}, 8'h00);

        // cts rises: delta bit 0
        hold(3'b111, 1'b1, 3);
        check("R2 cts delta set", rd_data, 8'h01);
        hold(3'b111, 1'b1, 2);
        check("R2 cts delta sticky", rd_data, 8'h01);
        // read shows flag during strobe, clears after
        cts_n_pin = 1'b1; rd_stb = 1'b1; #0.1;
        check("R6 byte during read", rd_data, 8'h01);
        @(posedge clk); @(negedge clk);
        compare();
        check("R6 cleared after read", rd_data, 8'h00);

        // dsr with interrupt disabled
        hold(3'b101, 1'b0, 4);
        step(3'b101, 1'b1, 1'b0);
        hold(3'b111, 1'b0, 3);
        check("R3 dsr delta set", rd_data, 8'h02);
        check("R10 irq gated", {7'd0, msi_irq}, 8'h00);
        step(3'b111, 1'b0, 1'b1);
        check("R10 irq after enable", {7'd0, msi_irq}, 8'h01);
        step(3'b111, 1'b1, 1'b1);

        // dcd
        hold(3'b011, 1'b1, 4);
        check("R1 dcd level", rd_data, 8'h80);
        step(3'b011, 1'b1, 1'b1);
        hold(3'b111, 1'b1, 3);
        check("R4 dcd delta set", rd_data, 8'h08);
        step(3'b111, 1'b1, 1'b1);

        // R7 edge detected in the clock of the clearing read
        hold(3'b110, 1'b1, 4);
        step(3'b110, 1'b1, 1'b1);
        step(3'b111, 1'b0, 1'b1);
        step(3'b111, 1'b0, 1'b1);
        step(3'b111, 1'b1, 1'b1);
        check("R7 delta survives read", {7'd0, rd_data[0]}, 8'h01);
        check("R7 irq survives read", {7'd0, msi_irq}, 8'h01);
        step(3'b111, 1'b1, 1'b1);

        // constrained random mix
        pins = 3'b111;
        en   = 1'b1;
        for (int i = 0; i < 4000; i++) begin
            for (int b = 0; b < 3; b++)
                if ($urandom_range(5) == 0) pins[b] = ~pins[b];
            if ($urandom_range(15) == 0) en = ~en;
            step(pins, ($urandom_range(3) == 0), en);
        end

        done = 1;
        finish_run();
    end

endmodule